// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Result Pair

This block is the integer multiply and divide engine of a simple processor. It works one operand bit per clock, so it needs no hard multiplier or divider. Results go into two dedicated result registers, `hi` and `lo`, and never into the register file. The core moves them in and out with separate write strobes and the always-visible outputs `hi_q` and `lo_q`.

A one-cycle `start` pulse starts an operation. The pulse carries an operation code and two operands. A multiply leaves the 64-bit product split over the pair, with the upper half in `hi`. A divide leaves the quotient in `lo` and the remainder in `hi`. The two accumulate forms add the product to whatever the pair already holds. While the unit works, `busy` is high. The surrounding pipeline must use `busy` to hold off readers, because the unit itself only reports it.

Top module: `mdu_top`

## Requirements
- R1: After reset, `hi_q` and `lo_q` are zero and `busy` is low.
- R2: Op code 0 (unsigned multiply) leaves the upper 32 bits of the unsigned 64-bit product of `opa` and `opb` in `hi_q` and the lower 32 bits in `lo_q`.
- R3: Op code 1 (signed multiply) does the same for the two's-complement product.
- R4: Op code 2 (unsigned divide) with a nonzero `opb` leaves `opa / opb` in `lo_q` and `opa % opb` in `hi_q`.
- R5: Op code 3 (signed divide) with a nonzero `opb` rounds the quotient toward zero and gives the remainder the sign of the dividend. The most negative value divided by -1 gives quotient 0x80000000 and remainder 0.
- R6: For either divide with `opb` zero, `lo_q` becomes 0xFFFFFFFF, `hi_q` becomes `opa`, and no other indication is given.
- R7: Op code 4 (unsigned) and op code 5 (signed) add the 64-bit product to the current `{hi_q, lo_q}` value, modulo 2^64.
- R8: An accepted start raises `busy` in the next cycle. `busy` stays high for exactly 33 cycles. The pair holds steady while `busy` is high, and the new result appears in the same cycle that `busy` falls.
- R9: A `start` pulse while `busy` is high is ignored. It neither lengthens nor restarts the operation, and it does not change the result.
- R10: When idle, `hi_wr` or `lo_wr` loads `wr_data` into that register at the next clock edge. While `busy` is high, both strobes are ignored.
- R11: A `start` with op code 6 or 7 is ignored. `busy` stays low and the pair is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 3 | Operation code (0..5 valid) |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| hi_wr | input | 1 | Load `wr_data` into hi |
| lo_wr | input | 1 | Load `wr_data` into lo |
| wr_data | input | 32 | Data for the move writes |
| busy | output | 1 | Operation in progress |
| hi_q | output | 32 | Current hi register |
| lo_q | output | 32 | Current lo register |

## Verification
Multiplies use all-ones operands, which test the carry out of the top partial sum. They also use mixed-sign pairs and two most-negative values, which separate signed from unsigned correction. Divides cover a dividend smaller than the divisor and every sign combination, which shows the rounding direction and the sign of the remainder. They also cover the most-negative value over -1 and a zero divisor for both forms. Accumulates start from preloaded pairs, one product positive and one negative, so the sign extension into `hi` is visible. Stray start pulses and move writes are injected in the middle of an accumulate, where any effect would show up in the final pair.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    // Operation codes seen on the op port
    typedef enum logic [2:0] {
        OP_MULU = 3'd0,
        OP_MULS = 3'd1,
        OP_DIVU = 3'd2,
        OP_DIVS = 3'd3,
        OP_MACU = 3'd4,
        OP_MACS = 3'd5
    } mdu_op_e;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } mdu_state_e;

    // True for the op codes the unit executes
    function automatic logic op_is_valid(input logic [2:0] code);
        return code <= 3'(OP_MACS);
    endfunction

endpackage

// File: rtl/mdu_sign_prep.sv
// mdu_sign_prep: turns the operands into magnitudes for the unsigned
// iteration cores. It also works out the signs the result must take
// and sorts the op code into its classes.
// Assumes: op is a valid code whenever its outputs are used.
module mdu_sign_prep
    import mdu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] mag_a,
    output logic [WIDTH-1:0] mag_b,
    output logic             neg_main,
    output logic             neg_rem,
    output logic             is_div,
    output logic             is_mac,
    output logic             div_zero
);
    logic signed_op;
    logic a_neg;
    logic b_neg;

    // Classify the op code and form magnitudes and result signs
    always_comb begin
        signed_op = (op == 3'(OP_MULS)) || (op == 3'(OP_DIVS)) || (op == 3'(OP_MACS));
        is_div    = (op == 3'(OP_DIVU)) || (op == 3'(OP_DIVS));
        is_mac    = (op == 3'(OP_MACU)) || (op == 3'(OP_MACS));
        a_neg     = signed_op && opa[WIDTH-1];
        b_neg     = signed_op && opb[WIDTH-1];
        mag_a     = a_neg ? (~opa + 1'b1) : opa;
        mag_b     = b_neg ? (~opb + 1'b1) : opb;
        neg_main  = a_neg ^ b_neg;
        neg_rem   = a_neg;
        div_zero  = (opb == '0);
    end

endmodule

// File: rtl/mdu_mul_core.sv
// mdu_mul_core: unsigned shift-add multiplier that retires one
// multiplier bit per step. After WIDTH steps following a load, prod
// holds the full 2*WIDTH product.
// Assumes: the controller issues exactly WIDTH steps between loads.
module mdu_mul_core #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic [2*WIDTH-1:0] prod
);
    logic [WIDTH-1:0] mcand;
    logic [WIDTH:0]   part_sum;

    // Add the multiplicand into the upper half when the current bit is set
    always_comb begin
        part_sum = {1'b0, prod[2*WIDTH-1:WIDTH]} + (prod[0] ? {1'b0, mcand} : '0);
    end

    // Load operands, then shift the partial product right each step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand <= '0;
            prod  <= '0;
        end else if (load) begin
            mcand <= mcand_in;
            prod  <= {{WIDTH{1'b0}}, mplier_in};
        end else if (step) begin
            prod  <= {part_sum, prod[WIDTH-1:1]};
        end
    end

endmodule

// File: rtl/mdu_div_core.sv
// mdu_div_core: unsigned restoring divider that produces one quotient
// bit per step. After WIDTH steps following a load, quo and rem hold the
// quotient and remainder. A zero divisor gives an all-ones quotient.
// Assumes: the controller issues exactly WIDTH steps between loads.
module mdu_div_core #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] dividend_in,
    input  logic [WIDTH-1:0] divisor_in,
    output logic [WIDTH-1:0] quo,
    output logic [WIDTH-1:0] rem
);
    logic [WIDTH-1:0] dsr;
    logic [WIDTH:0]   shifted;
    logic [WIDTH:0]   trial;

    // Bring in the next dividend bit and try subtracting the divisor
    always_comb begin
        shifted = {rem, quo[WIDTH-1]};
        trial   = shifted - {1'b0, dsr};
    end

    // Keep the difference when it is non-negative, otherwise restore
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsr <= '0;
            quo <= '0;
            rem <= '0;
        end else if (load) begin
            dsr <= divisor_in;
            quo <= dividend_in;
            rem <= '0;
        end else if (step) begin
            if (trial[WIDTH]) begin
                rem <= shifted[WIDTH-1:0];
                quo <= {quo[WIDTH-2:0], 1'b0};
            end else begin
                rem <= trial[WIDTH-1:0];
                quo <= {quo[WIDTH-2:0], 1'b1};
            end
        end
    end

endmodule

// File: rtl/mdu_top.sv
// mdu_top: multi-cycle multiply/divide unit with a hi/lo result pair.
// An accepted start runs WIDTH iteration cycles, then one fix-up cycle
// that applies the signs, adds for accumulate, and writes hi/lo. Busy
// covers all WIDTH+1 cycles.
// Assumes: the consumer waits for busy low before reading hi_q/lo_q.
// Start pulses and move writes that arrive during busy are dropped.
module mdu_top
    import mdu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             hi_wr,
    input  logic             lo_wr,
    input  logic [WIDTH-1:0] wr_data,
    output logic             busy,
    output logic [WIDTH-1:0] hi_q,
    output logic [WIDTH-1:0] lo_q
);
    localparam int CW = $clog2(WIDTH);
    localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

    mdu_state_e state;
    logic [CW-1:0] cnt;
    logic accept;
    logic step;

    logic [WIDTH-1:0] mag_a, mag_b;
    logic neg_main, neg_rem, is_div, is_mac, div_zero;

    logic neg_main_q, neg_rem_q, is_div_q, is_mac_q, div_zero_q;
    logic [WIDTH-1:0] dvd_q;

    logic [2*WIDTH-1:0] prod;
    logic [WIDTH-1:0]   quo, rem;
    logic [2*WIDTH-1:0] prod_fixed;
    logic [WIDTH-1:0]   quo_fixed, rem_fixed;

    mdu_sign_prep #(.WIDTH(WIDTH)) u_prep (
        .op       (op),
        .opa      (opa),
        .opb      (opb),
        .mag_a    (mag_a),
        .mag_b    (mag_b),
        .neg_main (neg_main),
        .neg_rem  (neg_rem),
        .is_div   (is_div),
        .is_mac   (is_mac),
        .div_zero (div_zero)
    );

    mdu_mul_core #(.WIDTH(WIDTH)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .step      (step),
        .mcand_in  (mag_a),
        .mplier_in (mag_b),
        .prod      (prod)
    );

    mdu_div_core #(.WIDTH(WIDTH)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .step        (step),
        .dividend_in (mag_a),
        .divisor_in  (mag_b),
        .quo         (quo),
        .rem         (rem)
    );

    // Accept only valid starts while idle; step the cores while running
    always_comb begin
        accept = start && (state == ST_IDLE) && op_is_valid(op);
        step   = (state == ST_RUN);
        busy   = (state != ST_IDLE);
    end

    // Apply the result signs to the magnitude results
    always_comb begin
        prod_fixed = neg_main_q ? (~prod + 1'b1) : prod;
        quo_fixed  = neg_main_q ? (~quo + 1'b1) : quo;
        rem_fixed  = neg_rem_q ? (~rem + 1'b1) : rem;
    end

    // Sequence idle, WIDTH iteration cycles, and the fix-up cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (accept) state <= ST_RUN;
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_STEP) state <= ST_FIX;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Capture the operation's class, signs and dividend when accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_main_q <= 1'b0;
            neg_rem_q  <= 1'b0;
            is_div_q   <= 1'b0;
            is_mac_q   <= 1'b0;
            div_zero_q <= 1'b0;
            dvd_q      <= '0;
        end else if (accept) begin
            neg_main_q <= neg_main;
            neg_rem_q  <= neg_rem;
            is_div_q   <= is_div;
            is_mac_q   <= is_mac;
            div_zero_q <= div_zero;
            dvd_q      <= opa;
        end
    end

    // Write the result pair on fix-up; take move writes only when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (state == ST_FIX) begin
            if (is_div_q) begin
                if (div_zero_q) begin
                    hi_q <= dvd_q;
                    lo_q <= '1;
                end else begin
                    hi_q <= rem_fixed;
                    lo_q <= quo_fixed;
                end
            end else if (is_mac_q) begin
                {hi_q, lo_q} <= {hi_q, lo_q} + prod_fixed;
            end else begin
                {hi_q, lo_q} <= prod_fixed;
            end
        end else if (state == ST_IDLE) begin
            if (hi_wr) hi_q <= wr_data;
            if (lo_wr) lo_q <= wr_data;
        end
    end

endmodule

// File: rtl/mdu_checker.sv
// mdu_checker: protocol checks for mdu_top. A counter of consecutive busy
// cycles checks the length of each operation without deep history.
// Assumes: bound to every mdu_top instance through the bind below.
module mdu_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [2:0]       op,
    input logic             busy,
    input logic [WIDTH-1:0] hi_q,
    input logic [WIDTH-1:0] lo_q
);
    localparam int BW = $clog2(WIDTH + 2);
    localparam logic [BW-1:0] FULL = BW'(WIDTH);

    logic [BW-1:0] busy_cnt;

    // Count busy cycles that came before the current one
    always_ff @(posedge clk) begin
        if (!rst_n) busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else busy_cnt <= '0;
    end

    // R8, R11: busy only rises after a start with a valid op code
    assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(start) && ($past(op) <= 3'd5)));

    // R8, R10: result pair is frozen after the first busy cycle
    assert_pair_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(hi_q) && $stable(lo_q)));

    // R8: busy never lasts more than WIDTH+1 cycles
    assert_busy_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt <= FULL));

    // R9: a start during busy neither shortens nor restarts an operation
    assert_busy_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(busy_cnt) == FULL));

endmodule

bind mdu_top mdu_checker #(.WIDTH(WIDTH)) u_mdu_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .op    (op),
    .busy  (busy),
    .hi_q  (hi_q),
    .lo_q  (lo_q)
);

// File: tb/tb_mdu_top.sv
module tb_mdu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] opa = '0, opb = '0;
    logic        hi_wr = 1'b0, lo_wr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        busy;
    logic [31:0] hi_q, lo_q;

    int checks = 0;
    int errors = 0;
    logic [63:0] model = '0;
    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic        prev_busy = 1'b0;

    always #4 clk = ~clk;

    mdu_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
        .hi_wr(hi_wr), .lo_wr(lo_wr), .wr_data(wr_data),
        .busy(busy), .hi_q(hi_q), .lo_q(lo_q)
    );

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference result from the requirements
    function automatic logic [63:0] ref_result(input logic [2:0] o, input logic [31:0] a,
                                               input logic [31:0] b, input logic [63:0] acc);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint unsigned ua = {32'b0, a};
        longint unsigned ub = {32'b0, b};
        longint q, r;
        case (o)
            3'd0: return ua * ub;
            3'd1: return sa * sb;
            3'd2: return (b == 0) ? {a, 32'hFFFF_FFFF} : {a % b, a / b};
            3'd3: begin
                if (b == 0) return {a, 32'hFFFF_FFFF};
                q = sa / sb;
                r = sa % sb;
                return {r[31:0], q[31:0]};
            end
            3'd4: return acc + ua * ub;
            3'd5: return acc + 64'(sa * sb);
            default: return acc;
        endcase
    endfunction

    // Monitor: compare the pair when busy falls
    always @(negedge clk) begin
        if (prev_busy && !busy) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R8: unexpected result actual %h expected none", {hi_q, lo_q});
            end else begin
                check64(tag_q.pop_front(), {hi_q, lo_q}, exp_q.pop_front());
            end
        end
        prev_busy = busy;
    end

    // Driver: disturb 1 = stray start mid-run, 2 = move write mid-run
    task automatic do_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                         input string tag, input int disturb);
        model = ref_result(o, a, b, model);
        exp_q.push_back(model);
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b1; op = o; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0;
        check64("R8 busy first cycle", {63'b0, busy}, 64'd1);
        for (int i = 1; i <= 32; i++) begin
            @(negedge clk);
            if (i == 5 && disturb == 1) begin
                start = 1'b1; op = 3'd2; opa = 32'd1; opb = 32'd1;
            end
            if (i == 5 && disturb == 2) begin
                hi_wr = 1'b1; lo_wr = 1'b1; wr_data = 32'hDEAD_BEEF;
            end
            if (i == 6) begin
                start = 1'b0; hi_wr = 1'b0; lo_wr = 1'b0;
            end
        end
        check64("R8 busy last cycle", {63'b0, busy}, 64'd1);
        @(negedge clk);
        check64("R8 busy low after 33", {63'b0, busy}, 64'd0);
        if (disturb == 1) begin
            @(negedge clk);
            check64("R9 no restart", {63'b0, busy}, 64'd0);
        end
    endtask

    task automatic move_write(input logic h, input logic l, input logic [31:0] d);
        @(negedge clk);
        hi_wr = h; lo_wr = l; wr_data = d;
        @(negedge clk);
        hi_wr = 1'b0; lo_wr = 1'b0;
        if (h) model[63:32] = d;
        if (l) model[31:0] = d;
        check64("R10 move write", {hi_q, lo_q}, model);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check64("R1 hi reset", {32'b0, hi_q}, 64'd0);
        check64("R1 lo reset", {32'b0, lo_q}, 64'd0);
        check64("R1 busy reset", {63'b0, busy}, 64'd0);

        do_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 mulu all ones", 0);
        do_op(3'd0, 32'd12345, 32'd6789, "R2 mulu small", 0);
        do_op(3'd1, 32'hFFFF_FFFD, 32'd7, "R3 muls neg*pos", 0);
        do_op(3'd1, 32'h8000_0000, 32'h8000_0000, "R3 muls min*min", 0);
        do_op(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFE, "R3 muls neg*neg", 0);
        do_op(3'd2, 32'd100, 32'd7, "R4 divu", 0);
        do_op(3'd2, 32'd5, 32'd9, "R4 divu small dividend", 0);
        do_op(3'd2, 32'hFFFF_FFFF, 32'd1, "R4 divu by one", 0);
        do_op(3'd3, 32'hFFFF_FFF9, 32'd2, "R5 divs -7/2", 0);
        do_op(3'd3, 32'd7, 32'hFFFF_FFFE, "R5 divs 7/-2", 0);
        do_op(3'd3, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R5 divs -7/-2", 0);
        do_op(3'd3, 32'h8000_0000, 32'hFFFF_FFFF, "R5 divs min/-1", 0);
        do_op(3'd2, 32'h1234_5678, 32'd0, "R6 divu by zero", 0);
        do_op(3'd3, 32'hFFFF_FFFB, 32'd0, "R6 divs by zero", 0);

        move_write(1'b1, 1'b0, 32'h0000_0001);
        move_write(1'b0, 1'b1, 32'hFFFF_FFF0);
        do_op(3'd4, 32'd16, 32'd2, "R7 macu carry into hi", 0);
        do_op(3'd5, 32'hFFFF_FFFF, 32'd5, "R7 macs negative product", 0);
        do_op(3'd5, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R7 macs large", 0);

        do_op(3'd4, 32'd3, 32'd4, "R9 stray start ignored", 1);
        do_op(3'd4, 32'd9, 32'd9, "R10 write during busy ignored", 2);

        @(negedge clk);
        start = 1'b1; op = 3'd6; opa = 32'd3; opb = 32'd3;
        @(negedge clk);
        start = 1'b0;
        check64("R11 op 6 no busy", {63'b0, busy}, 64'd0);
        @(negedge clk);
        start = 1'b1; op = 3'd7;
        @(negedge clk);
        start = 1'b0;
        check64("R11 op 7 no busy", {63'b0, busy}, 64'd0);
        check64("R11 pair unchanged", {hi_q, lo_q}, model);

        repeat (2) @(negedge clk);
        check64("R8 all results seen", 64'(exp_q.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule